// File: doc/BRIEF.md
# Instruction Prefetch Queue with Multiplexed Bus

The block keeps a six-byte queue of instruction bytes ahead of the execution side. When the bus is free and the queue has room, it fetches code over one shared address/data bus. Every access on that bus is a fixed four-clock cycle. In the first clock the address is on the shared lines. In the second and third clocks the read strobe is high, and the returned data is taken at the end of the third clock. The fourth clock is idle. Each access moves either one 16-bit word or one byte.

The execution side takes bytes off the head of the queue one at a time, however long its instructions are. It can also ask for a data read. Data reads win the bus over prefetches that have not yet started. A taken jump is signalled with a redirect, which carries the new code address. The redirect empties the queue at once and restarts fetching from that address. Any code fetch already on the bus runs to the end, but its bytes are thrown away.

Top module: `prefetch_queue_bus`

## Requirements
- R1: The queue never holds more than 6 bytes. A word prefetch starts only when at least 2 slots are free, and a byte prefetch only when at least 1 slot is free. With no pops, the bus goes quiet once the queue is full.
- R2: Every bus access is exactly four clocks: `bus_ale` high with the address on `bus_ad_o` (and `bus_ad_oe` high) in clock 1, `bus_rd` high in clocks 2 and 3, data sampled from `bus_ad_i` at the end of clock 3, and both strobes low in clock 4. The next access may begin in the clock after clock 4.
- R3: `bus_word`=1 marks a word access, returned little-endian: `bus_ad_i[7:0]` is the byte at the address and `bus_ad_i[15:8]` is the byte at address+1. `bus_word`=0 marks a byte access, returned on `bus_ad_i[7:0]`.
- R4: A prefetch from an even fetch address reads a word and advances the fetch address by 2. A prefetch from an odd address reads one byte and advances it by 1.
- R5: `pop_valid` is high whenever the queue is non-empty, with the head byte on `pop_byte`. A clock with `pop` and `pop_valid` both high removes that byte. A `pop` while the queue is empty changes nothing, and the consumer waits.
- R6: A redirect empties the queue at that clock edge, so `pop_valid` is low in the next cycle. It loads the fetch address, starts no prefetch in that clock, and drops the data of a prefetch already in flight, which still completes on the bus.
- R7: When the bus becomes free while `dreq` is high, the data read is started before any prefetch. A cycle in progress is never cut short. `dack` is high for the single fourth clock of the data cycle, with the result on `drdata` (upper byte zero for a byte read).
- R8: Popped bytes are the memory bytes at consecutive addresses starting from the last redirect target, with fill and pop allowed in the same clock.
- R9: While reset is asserted, the queue is empty and no bus strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect | input | 1 | Flush queue and restart fetching |
| redirect_addr | input | AW | New code address |
| pop | input | 1 | Consumer takes the head byte |
| pop_valid | output | 1 | Head byte present |
| pop_byte | output | 8 | Head byte |
| dreq | input | 1 | Data read request, held until `dack` |
| dreq_addr | input | AW | Data read address |
| dreq_word | input | 1 | 1 = word read, 0 = byte read |
| dack | output | 1 | Data read result valid |
| drdata | output | 16 | Data read result |
| bus_ale | output | 1 | Address phase strobe |
| bus_rd | output | 1 | Read strobe |
| bus_word | output | 1 | Access width of current cycle |
| bus_ad_oe | output | 1 | Block drives the shared lines |
| bus_ad_o | output | AW | Address driven on the shared lines |
| bus_ad_i | input | 16 | Data returned on the shared lines |

## Verification
The hardest case to reach is a redirect that lands on the one clock edge where an in-flight code fetch would deposit its bytes. At that edge, clearing the queue and filling it compete. Another hard case is a data request that appears while the last clock of another cycle is ending. The stimulus waits for the address strobe of a prefetch. It then delays the redirect by a swept number of clocks, from zero to five, so every phase of the cycle is hit. Data reads are issued both while the queue is full and while the consumer is draining it.

// File: rtl/prefetch_queue_bus.sv
module prefetch_queue_bus #(
  parameter int AW = 16,
  parameter int DEPTH = 6,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_addr,
  input  logic          pop,
  output logic          pop_valid,
  output logic [7:0]    pop_byte,
  input  logic          dreq,
  input  logic [AW-1:0] dreq_addr,
  input  logic          dreq_word,
  output logic          dack,
  output logic [15:0]   drdata,
  output logic          bus_ale,
  output logic          bus_rd,
  output logic          bus_word,
  output logic          bus_ad_oe,
  output logic [AW-1:0] bus_ad_o,
  input  logic [15:0]   bus_ad_i
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    qmem [DEPTH];
  logic [PW-1:0] rp;
  logic [CW-1:0] cnt;
  logic          busy, own_d, xw, drop;
  logic [1:0]    ph;
  logic [AW-1:0] xa, fptr;
  logic [15:0]   rdat;

  function automatic logic [PW-1:0] wrap(input int v);
    return PW'(v % DEPTH);
  endfunction

  wire avail   = !busy || ph == 2'd3;
  wire dack_w  = busy && ph == 2'd3 && own_d;
  wire do_pop  = pop && cnt != '0;
  wire cap     = busy && ph == 2'd2;
  wire push    = cap && !own_d && !drop && !redirect;
  wire pf_ok   = fptr[0] ? (cnt <= CW'(DEPTH - 1)) : (cnt <= CW'(DEPTH - 2));
  wire start_d = avail && dreq && !dack_w;
  wire start_p = avail && !start_d && !redirect && pf_ok;

  always_ff @(posedge clk) begin
    if (push) begin
      qmem[wrap(int'(rp) + int'(cnt))] <= bus_ad_i[7:0];
      if (xw) qmem[wrap(int'(rp) + int'(cnt) + 1)] <= bus_ad_i[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0;
      cnt <= '0;
    end else begin
      if (do_pop && !redirect) rp <= wrap(int'(rp) + 1);
      if (redirect) cnt <= '0;
      else cnt <= cnt - CW'(do_pop) + (push ? (xw ? CW'(2) : CW'(1)) : CW'(0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph <= 2'd0;
      own_d <= 1'b0;
      xw <= 1'b0;
      xa <= '0;
      drop <= 1'b0;
      fptr <= RESET_ADDR;
      rdat <= '0;
    end else begin
      if (cap && own_d) rdat <= xw ? bus_ad_i : {8'h00, bus_ad_i[7:0]};
      if (start_d || start_p) begin
        busy <= 1'b1;
        ph <= 2'd0;
        drop <= 1'b0;
        own_d <= start_d;
        xw <= start_d ? dreq_word : !fptr[0];
        xa <= start_d ? dreq_addr : fptr;
      end else begin
        if (avail) busy <= 1'b0;
        else ph <= ph + 2'd1;
        if (redirect) drop <= 1'b1;
      end
      if (redirect) fptr <= redirect_addr;
      else if (start_p) fptr <= fptr + (fptr[0] ? AW'(1) : AW'(2));
    end
  end

  assign pop_valid = cnt != '0;
  assign pop_byte  = qmem[rp];
  assign dack      = dack_w;
  assign drdata    = rdat;
  assign bus_ale   = busy && ph == 2'd0;
  assign bus_ad_oe = bus_ale;
  assign bus_ad_o  = bus_ale ? xa : '0;
  assign bus_rd    = busy && (ph == 2'd1 || ph == 2'd2);
  assign bus_word  = busy && xw;
endmodule

// File: rtl/prefetch_queue_checks.sv
module prefetch_queue_checks #(
  parameter int AW = 16,
  parameter int DEPTH = 6,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          own_d,
  input logic          redirect,
  input logic          pop_valid,
  input logic          dack,
  input logic          bus_ale,
  input logic          bus_rd,
  input logic          bus_word,
  input logic [AW-1:0] bus_ad_o
);
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_cycle_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> (bus_rd && !bus_ale) ##1 (bus_rd && !bus_ale) ##1 (!bus_rd && !bus_ale));

  p_word_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale && !own_d && bus_word) |-> !bus_ad_o[0]);

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !pop_valid);

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> !dack);

  p_ack_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (!bus_rd && $past(bus_rd)));
endmodule

bind prefetch_queue_bus prefetch_queue_checks #(.AW(AW), .DEPTH(DEPTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .own_d(own_d), .redirect(redirect),
  .pop_valid(pop_valid), .dack(dack), .bus_ale(bus_ale), .bus_rd(bus_rd),
  .bus_word(bus_word), .bus_ad_o(bus_ad_o)
);

// File: tb/test_prefetch_queue_bus.sv
`timescale 1ns/1ps
module test_prefetch_queue_bus;
  logic clk = 1'b0, rst_n = 1'b0;
  logic redirect = 1'b0, pop = 1'b0, dreq = 1'b0, dreq_word = 1'b0;
  logic [15:0] redirect_addr = '0, dreq_addr = '0;
  logic pop_valid, dack, bus_ale, bus_rd, bus_word, bus_ad_oe;
  logic [7:0] pop_byte;
  logic [15:0] drdata, bus_ad_o, bus_ad_i;

  always #2.5 clk = ~clk;

  prefetch_queue_bus i_prefetch_queue_bus (.*);

  int vectors = 0, miscmp = 0, pop_rate = 0;
  bit done = 0;
  logic [15:0] exp_pc = '0;

  function automatic logic [7:0] mem_b(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ (a[15:8] + 8'h5B);
  endfunction

  logic [15:0] rsp_a = '0;
  logic rsp_w = 1'b0;
  always @(posedge clk) if (bus_ale) begin rsp_a <= bus_ad_o; rsp_w <= bus_word; end
  assign bus_ad_i = !bus_rd ? 16'h0000 :
                    rsp_w ? {mem_b(rsp_a + 16'd1), mem_b(rsp_a)} : {8'h00, mem_b(rsp_a)};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  logic [7:0] q[$];
  bit m_busy = 0, m_own = 0, m_w = 0, m_drop = 0;
  int m_ph = 0;
  logic [15:0] m_a = '0, m_fp = '0, m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_ph = 0; m_drop = 0; m_fp = '0; m_rd = '0;
    end else begin
      int c0;
      bit avail, dk;
      c0 = q.size();
      avail = !m_busy || m_ph == 3;
      dk = m_busy && m_ph == 3 && m_own;
      if (pop && c0 > 0) void'(q.pop_front());
      if (m_busy && m_ph == 2) begin
        if (m_own) m_rd = m_w ? {mem_b(m_a + 16'd1), mem_b(m_a)} : {8'h00, mem_b(m_a)};
        else if (!m_drop && !redirect) begin
          q.push_back(mem_b(m_a));
          if (m_w) q.push_back(mem_b(m_a + 16'd1));
        end
      end
      if (redirect) q.delete();
      if (avail && dreq && !dk) begin
        m_busy = 1; m_ph = 0; m_own = 1; m_w = dreq_word; m_a = dreq_addr; m_drop = 0;
      end else if (avail && !redirect && (m_fp[0] ? c0 <= 5 : c0 <= 4)) begin
        m_busy = 1; m_ph = 0; m_own = 0; m_w = !m_fp[0]; m_a = m_fp; m_drop = 0;
        m_fp = m_fp + (m_fp[0] ? 16'd1 : 16'd2);
      end else begin
        if (avail) m_busy = 0; else m_ph++;
        if (redirect) m_drop = 1;
      end
      if (redirect) m_fp = redirect_addr;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    bit e_ale;
    e_ale = m_busy && m_ph == 0;
    chk("R5", "pop_valid", pop_valid, q.size() > 0);
    if (q.size() > 0) chk("R5", "pop_byte", pop_byte, q[0]);
    chk("R2", "bus_ale", bus_ale, e_ale);
    chk("R2", "bus_rd", bus_rd, m_busy && (m_ph == 1 || m_ph == 2));
    if (e_ale) begin
      chk("R2", "bus_ad_o", bus_ad_o, m_a);
      chk("R3", "bus_word", bus_word, m_w);
    end
    chk("R7", "dack", dack, m_busy && m_ph == 3 && m_own);
    if (m_busy && m_ph == 3 && m_own) chk("R7", "drdata", drdata, m_rd);
  end

  initial forever begin
    @(negedge clk); #1;
    pop = ($urandom_range(99) < pop_rate);
    if (pop && pop_valid && !redirect && rst_n) begin
      chk("R8", "stream byte", pop_byte, mem_b(exp_pc));
      exp_pc = exp_pc + 16'd1;
    end
  end

  task automatic wait_ale();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (bus_ale) return;
    end
    chk("R2", "ale timeout", 0, 1);
  endtask

  task automatic redirect_to(input logic [15:0] a);
    @(negedge clk);
    redirect = 1; redirect_addr = a; exp_pc = a;
    @(negedge clk);
    redirect = 0;
    chk("R6", "empty after flush", pop_valid, 0);
  endtask

  task automatic data_read(input logic [15:0] a, input logic w);
    @(negedge clk);
    dreq = 1; dreq_addr = a; dreq_word = w;
    wait_ale();
    chk("R7", "data cycle first", bus_ad_o, a);
    for (int i = 0; i < 10 && !dack; i++) @(negedge clk);
    chk("R7", "read result", drdata,
        w ? {mem_b(a + 16'd1), mem_b(a)} : {8'h00, mem_b(a)});
    dreq = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R9", "reset pop_valid", pop_valid, 0);
    chk("R9", "reset strobes", {bus_ale, bus_rd, dack}, 0);
    rst_n = 1;
    repeat (40) @(negedge clk);
    begin
      int n = 0;
      repeat (20) begin @(negedge clk); if (bus_ale) n++; end
      chk("R1", "bus quiet when full", n, 0);
      chk("R1", "full queue valid", pop_valid, 1);
    end
    pop_rate = 50;
    repeat (200) @(negedge clk);
    redirect_to(16'h0123);
    wait_ale();
    chk("R4", "odd byte fetch addr", bus_ad_o, 16'h0123);
    chk("R4", "odd byte fetch width", bus_word, 0);
    wait_ale();
    chk("R4", "word fetch addr", bus_ad_o, 16'h0124);
    chk("R4", "word fetch width", bus_word, 1);
    for (int k = 0; k < 6; k++) begin
      wait_ale();
      repeat (k) @(negedge clk);
      redirect_to(16'h0200 + 16'(k * 16) + 16'(k & 1));
      repeat (15) @(negedge clk);
    end
    pop_rate = 0;
    repeat (30) @(negedge clk);
    data_read(16'h4000, 1);
    data_read(16'h4011, 0);
    pop_rate = 30;
    for (int k = 0; k < 6; k++) begin
      repeat (k + 1) @(negedge clk);
      data_read(16'h5000 + 16'(k * 3), k[0]);
    end
    pop_rate = 100;
    redirect_to(16'h7FFF);
    repeat (300) @(negedge clk);
    pop_rate = 0;
    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule